// File: doc/BRIEF.md
# Multichannel Rate-Reducing Transmit FIFO

This block carries transmit samples from a slow data-path clock domain, where each channel's words are wide, into a fast device clock domain, where each channel consumes narrower samples. The clock rate drops on the slow side, and the wider word there keeps the average data rate equal on both sides. The wide-to-narrow ratio is 1, 2, 4 or 8. Any other ratio, or more than eight channels, stops elaboration with an error.

Each channel has its own dual-clock store. In the slow domain, the block issues one-cycle request strobes while the channel is enabled and space remains. The requester answers each strobe with a looped-back valid and a word, and only that valid writes the store. In the device domain, every read strobe returns a valid one cycle later together with the next narrow slice. Slices come out least significant first, and a stored word is retired after its last slice. A read of an empty channel returns a valid with zero data and raises underflow. The per-channel enables are carried into the slow domain, and an underflow flag from the slow side is carried into the device domain. Pointers cross the clock boundary in Gray code through two-flop synchronizers. Each domain has its own synchronous reset.

Top module: `tx_rate_fifo`

## Requirements
- R1: Each bit of `dev_enable_i` appears on the same bit of `slow_enable_o` no later than the third rising `slow_clk` edge after it changes.
- R2: `slow_req_o[c]` pulses only while that channel's slow-side enable is high. The sum of stored words and unanswered requests never exceeds 2^AW (16 by default). With no reads, an enabled channel therefore issues exactly 16 requests and then stays quiet, and it issues none once disabled.
- R3: A word is stored only on a cycle where the looped-back `slow_valid_i[c]` is high. Data presented while that valid is low never reaches the output. Stored words leave in the order they were written.
- R4: Channel c's word occupies bits [c*WIDE_W +: WIDE_W] of `slow_data_i`, and its sample occupies bits [c*NARROW_W +: NARROW_W] of `dev_data_o`. Successive reads return slice 0 (bits [NARROW_W-1:0]) first, then slice 1, and so on. The next word starts only after slice RATIO-1.
- R5: `dev_valid_o[c]` is high in exactly the cycle after a cycle in which `dev_rd_i[c]` was high. While the valid is low, that channel's data field is zero.
- R6: A read of an empty channel returns a valid with all-zero data, raises `dev_unf_o` in the same cycle and does not advance the channel. A read of a non-empty channel does not raise underflow.
- R7: `slow_unf_i` held high for at least two `slow_clk` cycles drives `dev_unf_o` high within three `dev_clk` cycles. `dev_unf_o` falls again within three `dev_clk` cycles after the input falls, unless an empty read is in progress.
- R8: After reset, `slow_req_o`, `slow_enable_o`, `dev_valid_o`, `dev_data_o` and `dev_unf_o` are all zero.
- R9: Channels are independent. Reads on one channel, alone or in the same cycle as reads on others, never change the sequence another channel delivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Data-path clock |
| slow_rst | input | 1 | Synchronous reset, slow domain |
| slow_enable_o | output | NUM_CH | Per-channel enable carried into the slow domain |
| slow_req_o | output | NUM_CH | One-cycle request strobe for one word |
| slow_valid_i | input | NUM_CH | Looped-back valid that qualifies the word |
| slow_data_i | input | NUM_CH*WIDE_W | Wide words, channel c at [c*WIDE_W +: WIDE_W] |
| slow_unf_i | input | 1 | Underflow flag from the slow side |
| dev_clk | input | 1 | Device interface clock |
| dev_rst | input | 1 | Synchronous reset, device domain |
| dev_enable_i | input | NUM_CH | Per-channel enable from the device side |
| dev_rd_i | input | NUM_CH | Per-channel read strobe |
| dev_valid_o | output | NUM_CH | Valid returned one cycle after each read |
| dev_data_o | output | NUM_CH*NARROW_W | Narrow samples, channel c at [c*NARROW_W +: NARROW_W] |
| dev_unf_o | output | 1 | Underflow in the device domain |

## Verification
Reads are driven on a falling `dev_clk` edge and their valid and data are sampled on the next falling edge, because the response is due after one register. The underflow flag of an empty read is checked in that same cycle. Cross-domain results are checked with margin: enables after three `slow_clk` edges, the slow-side underflow after four `dev_clk` cycles, and request totals only after the fill has settled for tens of slow cycles. The bench's requester answers each strobe on the following slow cycle. It counts the words it supplies, so the expected slice on each channel and the point of emptiness come from that count alone.

// File: rtl/tx_rfifo_pkg.sv
`timescale 1ns/1ps
package tx_rfifo_pkg;

    localparam int MAX_CHANNELS = 8;

    // Legal wide-to-narrow width ratios are 1, 2, 4 and 8
    function automatic bit ratio_ok(input int wide_w, input int narrow_w);
        int r;
        if (narrow_w <= 0 || wide_w <= 0) return 1'b0;
        if (wide_w % narrow_w != 0) return 1'b0;
        r = wide_w / narrow_w;
        return (r == 1) || (r == 2) || (r == 4) || (r == 8);
    endfunction

endpackage

// File: rtl/rfifo_bit_sync.sv
`timescale 1ns/1ps
module rfifo_bit_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] held;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = d_i;
        s_d.held = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q_o = s_q.held;

endmodule

// File: rtl/rfifo_wr_chan.sv
`timescale 1ns/1ps
module rfifo_wr_chan #(
    parameter int WIDE_W = 64,
    parameter int AW     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en_i,
    input  logic                       valid_i,
    input  logic [WIDE_W-1:0]          data_i,
    input  logic [AW:0]                rgray_i,
    output logic                       req_o,
    output logic [AW:0]                wgray_o,
    output logic [(1<<AW)*WIDE_W-1:0]  mem_o
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int SUMW  = PW + 2;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic [PW-1:0] outst;
        logic          req;
    } wr_state_t;

    wr_state_t s_d, s_q;

    logic [PW-1:0]   rbin_d;
    logic [PW-1:0]   level_d;
    logic            full_d;
    logic            wr_en_d;
    logic            ret_d;
    logic [SUMW-1:0] commit_d;

    logic [WIDE_W-1:0] store_q [DEPTH];

    always_comb begin
        s_d      = s_q;
        rbin_d   = from_gray(rgray_i);
        level_d  = s_q.wbin - rbin_d;
        full_d   = (level_d == PW'(DEPTH));
        wr_en_d  = valid_i && !full_d;
        ret_d    = valid_i && (s_q.outst != '0);

        s_d.wbin  = s_q.wbin + PW'(wr_en_d);
        s_d.wgray = to_gray(s_d.wbin);
        s_d.outst = s_q.outst + PW'(s_q.req) - PW'(ret_d);

        // words held plus words promised plus the strobe now on the wire
        commit_d  = SUMW'(level_d) + SUMW'(s_q.outst) + SUMW'(s_q.req);
        s_d.req   = en_i && (commit_d < SUMW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en_d) store_q[s_q.wbin[AW-1:0]] <= data_i;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign mem_o[i*WIDE_W +: WIDE_W] = store_q[i];
    end

    assign req_o   = s_q.req;
    assign wgray_o = s_q.wgray;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level_d <= PW'(DEPTH)); // R2

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(en_i)); // R2

    AST_WPTR_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray_o ^ $past(wgray_o)) <= 1); // R3

endmodule

// File: rtl/rfifo_rd_chan.sv
`timescale 1ns/1ps
module rfifo_rd_chan #(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 16,
    parameter int AW       = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_i,
    input  logic [AW:0]                wgray_i,
    input  logic [(1<<AW)*WIDE_W-1:0]  mem_i,
    output logic [AW:0]                rgray_o,
    output logic                       valid_o,
    output logic [NARROW_W-1:0]        data_o,
    output logic                       unf_o
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int RATIO = WIDE_W / NARROW_W;
    localparam int SW    = (RATIO > 1) ? $clog2(RATIO) : 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    typedef struct packed {
        logic [PW-1:0]       rbin;
        logic [PW-1:0]       rgray;
        logic [SW-1:0]       slice;
        logic                valid;
        logic [NARROW_W-1:0] data;
        logic                unf;
    } rd_state_t;

    rd_state_t s_d, s_q;

    logic [PW-1:0]       wbin_d;
    logic                empty_d;
    logic                last_d;
    logic [WIDE_W-1:0]   word_d;
    logic [NARROW_W-1:0] part_d;

    always_comb begin
        s_d     = s_q;
        wbin_d  = from_gray(wgray_i);
        empty_d = (s_q.rbin == wbin_d);
        last_d  = (s_q.slice == SW'(RATIO - 1));
        word_d  = mem_i[int'(s_q.rbin[AW-1:0]) * WIDE_W +: WIDE_W];
        part_d  = word_d[int'(s_q.slice) * NARROW_W +: NARROW_W];

        s_d.valid = 1'b0;
        s_d.data  = '0;
        s_d.unf   = 1'b0;

        if (rd_i) begin
            s_d.valid = 1'b1;
            if (empty_d) begin
                s_d.unf = 1'b1;
            end else begin
                s_d.data = part_d;
                if (last_d) begin
                    s_d.slice = '0;
                    s_d.rbin  = s_q.rbin + PW'(1);
                end else begin
                    s_d.slice = s_q.slice + SW'(1);
                end
            end
        end
        s_d.rgray = to_gray(s_d.rbin);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rgray_o = s_q.rgray;
    assign valid_o = s_q.valid;
    assign data_o  = s_q.data;
    assign unf_o   = s_q.unf;

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> valid_o); // R5

    AST_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> !valid_o); // R5

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (data_o == '0)); // R5

    AST_UNF_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> (valid_o && data_o == '0)); // R6

    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        (wbin_d - s_q.rbin) <= PW'(DEPTH)); // R3

endmodule

// File: rtl/tx_rate_fifo.sv
`timescale 1ns/1ps
module tx_rate_fifo #(
    parameter int NUM_CH   = 4,
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 16,
    parameter int AW       = 4
) (
    input  logic                       slow_clk,
    input  logic                       slow_rst,
    output logic [NUM_CH-1:0]          slow_enable_o,
    output logic [NUM_CH-1:0]          slow_req_o,
    input  logic [NUM_CH-1:0]          slow_valid_i,
    input  logic [NUM_CH*WIDE_W-1:0]   slow_data_i,
    input  logic                       slow_unf_i,
    input  logic                       dev_clk,
    input  logic                       dev_rst,
    input  logic [NUM_CH-1:0]          dev_enable_i,
    input  logic [NUM_CH-1:0]          dev_rd_i,
    output logic [NUM_CH-1:0]          dev_valid_o,
    output logic [NUM_CH*NARROW_W-1:0] dev_data_o,
    output logic                       dev_unf_o
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int MEMW  = DEPTH * WIDE_W;

    if (!tx_rfifo_pkg::ratio_ok(WIDE_W, NARROW_W) ||
        NUM_CH < 1 || NUM_CH > tx_rfifo_pkg::MAX_CHANNELS) begin : g_bad_cfg
        $error("tx_rate_fifo: width ratio must be 1, 2, 4 or 8 and channels 1 to 8");
    end

    logic [NUM_CH-1:0] ch_unf;
    logic              unf_dev;

    rfifo_bit_sync #(.W(NUM_CH)) i_en_sync (
        .clk (slow_clk),
        .rst (slow_rst),
        .d_i (dev_enable_i),
        .q_o (slow_enable_o)
    );

    rfifo_bit_sync #(.W(1)) i_unf_sync (
        .clk (dev_clk),
        .rst (dev_rst),
        .d_i (slow_unf_i),
        .q_o (unf_dev)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [PW-1:0]   wgray;
        logic [PW-1:0]   wgray_dev;
        logic [PW-1:0]   rgray;
        logic [PW-1:0]   rgray_slow;
        logic [MEMW-1:0] mem;

        rfifo_wr_chan #(.WIDE_W(WIDE_W), .AW(AW)) i_wr (
            .clk     (slow_clk),
            .rst     (slow_rst),
            .en_i    (slow_enable_o[c]),
            .valid_i (slow_valid_i[c]),
            .data_i  (slow_data_i[c*WIDE_W +: WIDE_W]),
            .rgray_i (rgray_slow),
            .req_o   (slow_req_o[c]),
            .wgray_o (wgray),
            .mem_o   (mem)
        );

        rfifo_bit_sync #(.W(PW)) i_wptr_sync (
            .clk (dev_clk),
            .rst (dev_rst),
            .d_i (wgray),
            .q_o (wgray_dev)
        );

        rfifo_bit_sync #(.W(PW)) i_rptr_sync (
            .clk (slow_clk),
            .rst (slow_rst),
            .d_i (rgray),
            .q_o (rgray_slow)
        );

        rfifo_rd_chan #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .AW(AW)) i_rd (
            .clk     (dev_clk),
            .rst     (dev_rst),
            .rd_i    (dev_rd_i[c]),
            .wgray_i (wgray_dev),
            .mem_i   (mem),
            .rgray_o (rgray),
            .valid_o (dev_valid_o[c]),
            .data_o  (dev_data_o[c*NARROW_W +: NARROW_W]),
            .unf_o   (ch_unf[c])
        );
    end

    assign dev_unf_o = (|ch_unf) | unf_dev;

    AST_UNF_SOURCE: assert property (@(posedge dev_clk) disable iff (dev_rst)
        dev_unf_o |-> ((|(dev_valid_o & ch_unf)) || unf_dev)); // R7

endmodule

// File: tb/test_tx_rate_fifo.sv
`timescale 1ns/1ps
module test_tx_rate_fifo;

    localparam int NCH   = 4;
    localparam int WW    = 64;
    localparam int NW    = 16;
    localparam int AW    = 4;
    localparam int RATIO = WW / NW;
    localparam int DEPTH = 1 << AW;

    logic                slow_clk = 1'b0;
    logic                dev_clk  = 1'b0;
    logic                slow_rst = 1'b1;
    logic                dev_rst  = 1'b1;
    logic [NCH-1:0]      slow_enable_o;
    logic [NCH-1:0]      slow_req_o;
    logic [NCH-1:0]      slow_valid_i = '0;
    logic [NCH*WW-1:0]   slow_data_i  = '0;
    logic                slow_unf_i   = 1'b0;
    logic [NCH-1:0]      dev_enable_i = '0;
    logic [NCH-1:0]      dev_rd_i     = '0;
    logic [NCH-1:0]      dev_valid_o;
    logic [NCH*NW-1:0]   dev_data_o;
    logic                dev_unf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int written  [NCH];
    int consumed [NCH];
    int req_cnt  [NCH];
    bit pend     [NCH];

    always #2 dev_clk  = ~dev_clk;
    always #7 slow_clk = ~slow_clk;

    tx_rate_fifo #(.NUM_CH(NCH), .WIDE_W(WW), .NARROW_W(NW), .AW(AW)) i_tx_rate_fifo (
        .slow_clk      (slow_clk),
        .slow_rst      (slow_rst),
        .slow_enable_o (slow_enable_o),
        .slow_req_o    (slow_req_o),
        .slow_valid_i  (slow_valid_i),
        .slow_data_i   (slow_data_i),
        .slow_unf_i    (slow_unf_i),
        .dev_clk       (dev_clk),
        .dev_rst       (dev_rst),
        .dev_enable_i  (dev_enable_i),
        .dev_rd_i      (dev_rd_i),
        .dev_valid_o   (dev_valid_o),
        .dev_data_o    (dev_data_o),
        .dev_unf_o     (dev_unf_o)
    );

    function automatic logic [WW-1:0] mkword(input int c, input int k);
        logic [15:0] a, b, d, e;
        a = 16'(k * 3 + c * 7 + 1);
        b = 16'(k) ^ 16'h5a5a ^ 16'(c << 8);
        d = 16'((c << 12) | (k & 12'hfff)) ^ 16'h0c30;
        e = 16'(k + 256 * c) ^ 16'hf00f;
        return {e, d, b, a};
    endfunction

    function automatic logic [NW-1:0] exp_slice(input int c, input int idx);
        logic [WW-1:0] w;
        w = mkword(c, idx / RATIO);
        return w[(idx % RATIO) * NW +: NW];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // requester: answers each strobe on the following slow cycle
    initial begin
        for (int c = 0; c < NCH; c++) begin
            written[c] = 0; consumed[c] = 0; req_cnt[c] = 0; pend[c] = 1'b0;
        end
        forever begin
            @(negedge slow_clk);
            for (int c = 0; c < NCH; c++) begin
                slow_valid_i[c] = pend[c];
                if (pend[c]) begin
                    slow_data_i[c*WW +: WW] = mkword(c, written[c]);
                    written[c]++;
                end else begin
                    slow_data_i[c*WW +: WW] = {$urandom, $urandom};
                end
                pend[c] = slow_req_o[c];
                if (slow_req_o[c]) req_cnt[c]++;
            end
        end
    end

    // one device cycle: drive reads, check response on the next falling edge
    task automatic dev_cycle(input logic [NCH-1:0] rd, input string tag);
        logic exp_unf;
        int   rem;
        exp_unf  = 1'b0;
        dev_rd_i = rd;
        @(negedge dev_clk);
        for (int c = 0; c < NCH; c++) begin
            if (rd[c]) begin
                rem = written[c] * RATIO - consumed[c];
                if (rem > 0) begin
                    chk($sformatf("%s ch%0d data", tag, c),
                        64'({dev_valid_o[c], dev_data_o[c*NW +: NW]}),
                        64'({1'b1, exp_slice(c, consumed[c])}));
                    consumed[c]++;
                end else begin
                    exp_unf = 1'b1;
                    chk($sformatf("R6 ch%0d empty read", c),
                        64'({dev_valid_o[c], dev_data_o[c*NW +: NW]}),
                        64'({1'b1, 16'h0000}));
                end
            end else begin
                chk($sformatf("R5 ch%0d idle", c),
                    64'({dev_valid_o[c], dev_data_o[c*NW +: NW]}), 64'(0));
            end
        end
        chk($sformatf("R6 unf (%s)", tag), 64'(dev_unf_o), 64'(exp_unf));
        dev_rd_i = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (10) @(negedge slow_clk);
        slow_rst = 1'b0;
        dev_rst  = 1'b0;
        @(negedge slow_clk);
        chk("R8 slow_req_o", 64'(slow_req_o), 64'(0));
        chk("R8 slow_enable_o", 64'(slow_enable_o), 64'(0));
        @(negedge dev_clk);
        chk("R8 dev_valid_o", 64'(dev_valid_o), 64'(0));
        chk("R8 dev_data_o", 64'(dev_data_o), 64'(0));
        chk("R8 dev_unf_o", 64'(dev_unf_o), 64'(0));

        // R1: enable crossing
        dev_enable_i = '1;
        repeat (3) @(negedge slow_clk);
        chk("R1 enable rise", 64'(slow_enable_o), 64'({NCH{1'b1}}));

        // R2: fill without reads stops at the depth
        repeat (80) @(negedge slow_clk);
        for (int c = 0; c < NCH; c++) begin
            chk($sformatf("R2 ch%0d requests", c), 64'(req_cnt[c]), 64'(DEPTH));
            chk($sformatf("R3 ch%0d words supplied", c), 64'(written[c]), 64'(DEPTH));
        end

        // R4: slice order on one word, directed
        @(negedge dev_clk);
        for (int i = 0; i < RATIO; i++) dev_cycle(4'b0001, "R4 slice order");
        dev_cycle(4'b0001, "R4 next word");

        // R9/R3: random reads across channels
        for (int i = 0; i < 400; i++) begin
            logic [NCH-1:0] rd;
            rd = NCH'($urandom) & NCH'($urandom);
            dev_cycle(rd, "R9 random");
        end
        dev_cycle(4'b1111, "R9 all channels");

        // R7: slow-side underflow flag
        @(negedge slow_clk);
        slow_unf_i = 1'b1;
        repeat (2) @(negedge slow_clk);
        @(negedge dev_clk);
        chk("R7 unf raised", 64'(dev_unf_o), 64'(1));
        slow_unf_i = 1'b0;
        repeat (4) @(negedge dev_clk);
        chk("R7 unf cleared", 64'(dev_unf_o), 64'(0));

        // R1/R2: disable stops requests
        dev_enable_i = '0;
        repeat (3) @(negedge slow_clk);
        chk("R1 enable fall", 64'(slow_enable_o), 64'(0));
        repeat (5) @(negedge slow_clk);
        begin
            int snap;
            snap = req_cnt[0] + req_cnt[1];
            repeat (20) @(negedge slow_clk);
            chk("R2 no requests when disabled", 64'(req_cnt[0] + req_cnt[1]), 64'(snap));
        end

        // R4/R6: drain channel 0, then read it empty
        @(negedge dev_clk);
        while (written[0] * RATIO - consumed[0] > 0) dev_cycle(4'b0001, "R4 drain");
        dev_cycle(4'b0001, "R6 first empty read");
        dev_cycle(4'b0001, "R6 second empty read");
        dev_cycle(4'b0010, "R9 other channel intact");
        dev_cycle(4'b0000, "R6 unf clears");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule